// File: doc/BRIEF.md
# Host-to-Coprocessor Byte Mailbox

The block is a byte-wide mailbox between a host processor and a sound coprocessor that share one clock. Each side sees a plain synchronous register port with a chip select and read and write strobes. The host uses a 2-bit register select. The coprocessor uses an 8-bit port address.

The host sends a command byte and exchanges data bytes in both directions. Two flags track the exchange. The command flag means "a new command is waiting". The data flag tracks the data hand-off in either direction. Both flags change only as side effects of port accesses. The flag rules differ between the two sides. When a set event and a clear event hit the same flag in one cycle, the set event wins.

A legacy alias port forces the data flag to the inverse of the low bit of the coprocessor's memory-page register. That bit comes in as an input. A host write to the control register produces one-cycle request pulses for a coprocessor reset, an NMI and an LED toggle.

Top module: `mbox_top`

## Requirements
- R1: After reset both flags are 0 and the command, inbound and outbound bytes are 0x00.
- R2: A host read with select 0 returns the status byte: the command flag in bit 0, the data flag in bit 7, and zeros elsewhere. Reads of any port not otherwise defined, on either side, return 0x00.
- R3: A host write with select 0 stores the command byte and sets the command flag. A coprocessor read of address 0x01 returns the stored command byte.
- R4: Any read or write at coprocessor address 0x05 clears the command flag.
- R5: A host write with select 1 stores the inbound byte and sets the data flag. A coprocessor read of address 0x02 returns that byte and clears the data flag.
- R6: A coprocessor write to address 0x03 stores the outbound byte and sets the data flag. A host read with select 1 returns that byte and clears the data flag.
- R7: A coprocessor read of address 0x04 returns the same status byte layout as R2.
- R8: Any read or write at coprocessor address 0x0A sets the data flag to the inverse of page_lsb_i.
- R9: When a set event and a clear event reach the same flag in one cycle, the flag ends up set.
- R10: A host write with select 2 raises core_reset_o, core_nmi_o and led_toggle_o for exactly the following cycle. Each output takes its value from write-data bit 7, bit 6 and bit 5 respectively.
- R11: Strobes with the chip select low change no stored byte and no flag.
- R12: Flag and byte updates appear in the cycle after the strobe. A read in the same cycle as an update returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_cs_i | input | 1 | Host chip select |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Host register select: 0 command/status, 1 data, 2 control |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| cp_cs_i | input | 1 | Coprocessor chip select |
| cp_rd_i | input | 1 | Coprocessor read strobe |
| cp_wr_i | input | 1 | Coprocessor write strobe |
| cp_addr_i | input | 8 | Coprocessor port address |
| cp_wdata_i | input | 8 | Coprocessor write data |
| cp_rdata_o | output | 8 | Coprocessor read data |
| page_lsb_i | input | 1 | Bit 0 of the coprocessor memory-page register |
| core_reset_o | output | 1 | One-cycle coprocessor reset request |
| core_nmi_o | output | 1 | One-cycle NMI request |
| led_toggle_o | output | 1 | One-cycle LED toggle request |

## Verification
The assertions assume that a side never raises its read and write strobes together. They also assume that every strobe lasts one clock, so a single access is never counted as two side effects. The stimulus drives each access for exactly one cycle with only one strobe per side. It puts host and coprocessor accesses in the same cycle only where a set-versus-clear collision is the point of the test. The alias-port accesses are made with page_lsb_i both high and low, and in a state where the data flag already differs from the forced value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HSEL_W = 2;
  localparam int unsigned CFLAG_POS = 0;
  localparam int unsigned DFLAG_POS = 7;

  typedef enum logic [HSEL_W-1:0] {
    HSEL_CMD  = 2'd0,
    HSEL_DATA = 2'd1,
    HSEL_CTRL = 2'd2,
    HSEL_NONE = 2'd3
  } host_sel_e;

  function automatic logic [BYTE_W-1:0] status_byte(input logic cflag, input logic dflag);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[CFLAG_POS] = cflag;
    s[DFLAG_POS] = dflag;
    return s;
  endfunction
endpackage

// File: rtl/mbox_host_dec.sv
module mbox_host_dec
  import mbox_pkg::*;
(
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [HSEL_W-1:0] sel_i,
  output logic              cmd_we_o,
  output logic              stat_re_o,
  output logic              data_we_o,
  output logic              data_re_o,
  output logic              ctrl_we_o
);
  host_sel_e sel;
  assign sel = host_sel_e'(sel_i);

  always_comb begin
    cmd_we_o  = cs_i && wr_i && (sel == HSEL_CMD);
    stat_re_o = cs_i && rd_i && (sel == HSEL_CMD);
    data_we_o = cs_i && wr_i && (sel == HSEL_DATA);
    data_re_o = cs_i && rd_i && (sel == HSEL_DATA);
    ctrl_we_o = cs_i && wr_i && (sel == HSEL_CTRL);
  end
endmodule

// File: rtl/mbox_cp_dec.sv
module mbox_cp_dec #(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CMD_RD_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] IN_RD_ADDR  = 'h02,
  parameter logic [ADDR_W-1:0] OUT_WR_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h04,
  parameter logic [ADDR_W-1:0] CCLR_ADDR   = 'h05,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR  = 'h0A
) (
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_re_o,
  output logic              in_re_o,
  output logic              out_we_o,
  output logic              stat_re_o,
  output logic              cclr_o,
  output logic              alias_o
);
  logic acc;
  assign acc = cs_i && (rd_i || wr_i);

  always_comb begin
    cmd_re_o  = cs_i && rd_i && (addr_i == CMD_RD_ADDR);
    in_re_o   = cs_i && rd_i && (addr_i == IN_RD_ADDR);
    out_we_o  = cs_i && wr_i && (addr_i == OUT_WR_ADDR);
    stat_re_o = cs_i && rd_i && (addr_i == STAT_ADDR);
    cclr_o    = acc && (addr_i == CCLR_ADDR);
    alias_o   = acc && (addr_i == ALIAS_ADDR);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set has priority
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_o);
  assert_clear_alone_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/mbox_ctrl_pulse.sv
module mbox_ctrl_pulse #(
  parameter int unsigned REQ_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REQ_W-1:0] req_i,
  output logic [REQ_W-1:0] pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= '0;
    else         pulse_o <= we_i ? req_i : '0;
  end

  assert_pulse_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (pulse_o == $past(req_i)));
  assert_pulse_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (pulse_o == '0));
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int unsigned CP_ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_cs_i,
  input  logic                 host_rd_i,
  input  logic                 host_wr_i,
  input  logic [HSEL_W-1:0]    host_addr_i,
  input  logic [BYTE_W-1:0]    host_wdata_i,
  output logic [BYTE_W-1:0]    host_rdata_o,
  input  logic                 cp_cs_i,
  input  logic                 cp_rd_i,
  input  logic                 cp_wr_i,
  input  logic [CP_ADDR_W-1:0] cp_addr_i,
  input  logic [BYTE_W-1:0]    cp_wdata_i,
  output logic [BYTE_W-1:0]    cp_rdata_o,
  input  logic                 page_lsb_i,
  output logic                 core_reset_o,
  output logic                 core_nmi_o,
  output logic                 led_toggle_o
);
  localparam int unsigned REQ_W = 3;

  logic h_cmd_we, h_stat_re, h_data_we, h_data_re, h_ctrl_we;
  logic c_cmd_re, c_in_re, c_out_we, c_stat_re, c_cclr, c_alias;
  logic cflag, dflag;
  logic cf_set, cf_clr, df_set, df_clr;
  logic [BYTE_W-1:0] cmd_q, in_q, out_q;
  logic [REQ_W-1:0] pulses;

  mbox_host_dec u_host_dec (
    .cs_i(host_cs_i), .rd_i(host_rd_i), .wr_i(host_wr_i), .sel_i(host_addr_i),
    .cmd_we_o(h_cmd_we), .stat_re_o(h_stat_re), .data_we_o(h_data_we),
    .data_re_o(h_data_re), .ctrl_we_o(h_ctrl_we)
  );

  mbox_cp_dec #(.ADDR_W(CP_ADDR_W)) u_cp_dec (
    .cs_i(cp_cs_i), .rd_i(cp_rd_i), .wr_i(cp_wr_i), .addr_i(cp_addr_i),
    .cmd_re_o(c_cmd_re), .in_re_o(c_in_re), .out_we_o(c_out_we),
    .stat_re_o(c_stat_re), .cclr_o(c_cclr), .alias_o(c_alias)
  );

  // alias access becomes a set or a clear event depending on the page bit
  assign cf_set = h_cmd_we;
  assign cf_clr = c_cclr;
  assign df_set = h_data_we || c_out_we || (c_alias && !page_lsb_i);
  assign df_clr = h_data_re || c_in_re  || (c_alias &&  page_lsb_i);

  mbox_flag u_cflag (.clk_i, .rst_ni, .set_i(cf_set), .clr_i(cf_clr), .flag_o(cflag));
  mbox_flag u_dflag (.clk_i, .rst_ni, .set_i(df_set), .clr_i(df_clr), .flag_o(dflag));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (h_cmd_we)  cmd_q <= host_wdata_i;
      if (h_data_we) in_q  <= host_wdata_i;
      if (c_out_we)  out_q <= cp_wdata_i;
    end
  end

  mbox_ctrl_pulse #(.REQ_W(REQ_W)) u_ctrl (
    .clk_i, .rst_ni, .we_i(h_ctrl_we), .req_i(host_wdata_i[7:5]), .pulse_o(pulses)
  );
  assign {core_reset_o, core_nmi_o, led_toggle_o} = pulses;

  always_comb begin
    host_rdata_o = '0;
    if (h_stat_re)      host_rdata_o = status_byte(cflag, dflag);
    else if (h_data_re) host_rdata_o = out_q;
  end

  always_comb begin
    cp_rdata_o = '0;
    if (c_cmd_re)       cp_rdata_o = cmd_q;
    else if (c_in_re)   cp_rdata_o = in_q;
    else if (c_stat_re) cp_rdata_o = status_byte(cflag, dflag);
  end

  assert_cmd_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_cs_i && host_wr_i && host_addr_i == 2'd0) |=> (cflag && cmd_q == $past(host_wdata_i)));
  assert_cmd_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_cs_i && (cp_rd_i || cp_wr_i) && cp_addr_i == 8'h05 &&
     !(host_cs_i && host_wr_i && host_addr_i == 2'd0)) |=> !cflag);
  assert_out_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_cs_i && cp_wr_i && cp_addr_i == 8'h03) |=> (dflag && out_q == $past(cp_wdata_i)));
  assert_alias_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_alias && !(host_cs_i && (host_rd_i || host_wr_i) && host_addr_i == 2'd1))
    |=> (dflag == !$past(page_lsb_i)));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_cs_i && !cp_cs_i) |=> ($stable(cflag) && $stable(dflag) &&
                                  $stable(cmd_q) && $stable(in_q) && $stable(out_q)));
endmodule

// File: tb/mbox_top_tb_top.sv
module mbox_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       hcs = 0, hrd = 0, hwr = 0;
  logic [1:0] haddr = 0;
  logic [7:0] hwd = 0, hrdata;
  logic       ccs = 0, crd = 0, cwr = 0;
  logic [7:0] caddr = 0, cwd = 0, crdata;
  logic       plsb = 0;
  logic       o_rst, o_nmi, o_led;

  mbox_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_cs_i(hcs), .host_rd_i(hrd), .host_wr_i(hwr), .host_addr_i(haddr),
    .host_wdata_i(hwd), .host_rdata_o(hrdata),
    .cp_cs_i(ccs), .cp_rd_i(crd), .cp_wr_i(cwr), .cp_addr_i(caddr),
    .cp_wdata_i(cwd), .cp_rdata_o(crdata), .page_lsb_i(plsb),
    .core_reset_o(o_rst), .core_nmi_o(o_nmi), .led_toggle_o(o_led)
  );

  typedef struct { logic [7:0] v; string r; } exp_t;
  exp_t hq[$];
  exp_t cq[$];
  int checks = 0, errors = 0;

  // reference model state
  logic [7:0] m_cmd = 0, m_in = 0, m_out = 0;
  logic m_cf = 0, m_df = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic cf, input logic df);
    return {df, 6'b0, cf};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    #5;
    if (hcs && hrd) begin
      if (hq.size() == 0) chk(hrdata, 8'hxx, "host-queue");
      else begin exp_t e; e = hq.pop_front(); chk(hrdata, e.v, e.r); end
    end
    if (ccs && crd) begin
      if (cq.size() == 0) chk(crdata, 8'hxx, "cp-queue");
      else begin exp_t e; e = cq.pop_front(); chk(crdata, e.v, e.r); end
    end
  end

  task automatic cyc(input logic h_cs, input logic h_rd, input logic h_wr,
                     input logic [1:0] h_a, input logic [7:0] h_d,
                     input logic c_cs, input logic c_rd, input logic c_wr,
                     input logic [7:0] c_a, input logic [7:0] c_d,
                     input logic pl, input string r);
    logic cfs, cfc, dfs, dfc, alias_acc;
    logic [2:0] exp_p;
    exp_t e;
    @(negedge clk);
    e.r = r;
    if (h_cs && h_rd) begin
      e.v = (h_a == 2'd0) ? stat(m_cf, m_df) : (h_a == 2'd1) ? m_out : 8'h00;
      hq.push_back(e);
    end
    if (c_cs && c_rd) begin
      e.v = (c_a == 8'h01) ? m_cmd : (c_a == 8'h02) ? m_in :
            (c_a == 8'h04) ? stat(m_cf, m_df) : 8'h00;
      cq.push_back(e);
    end
    alias_acc = c_cs && (c_rd || c_wr) && c_a == 8'h0A;
    cfs = h_cs && h_wr && h_a == 2'd0;
    cfc = c_cs && (c_rd || c_wr) && c_a == 8'h05;
    dfs = (h_cs && h_wr && h_a == 2'd1) || (c_cs && c_wr && c_a == 8'h03) || (alias_acc && !pl);
    dfc = (h_cs && h_rd && h_a == 2'd1) || (c_cs && c_rd && c_a == 8'h02) || (alias_acc && pl);
    exp_p = (h_cs && h_wr && h_a == 2'd2) ? h_d[7:5] : 3'b000;
    hcs = h_cs; hrd = h_rd; hwr = h_wr; haddr = h_a; hwd = h_d;
    ccs = c_cs; crd = c_rd; cwr = c_wr; caddr = c_a; cwd = c_d; plsb = pl;
    if (cfs) m_cmd = h_d;
    if (h_cs && h_wr && h_a == 2'd1) m_in = h_d;
    if (c_cs && c_wr && c_a == 8'h03) m_out = c_d;
    m_cf = cfs ? 1'b1 : cfc ? 1'b0 : m_cf;
    m_df = dfs ? 1'b1 : dfc ? 1'b0 : m_df;
    @(negedge clk);
    hcs = 0; hrd = 0; hwr = 0; ccs = 0; crd = 0; cwr = 0;
    #5;
    chk({5'b0, o_rst, o_nmi, o_led}, {5'b0, exp_p}, {r, " ctrl-pulse R10"});
  endtask

  task automatic h_wr(input logic [1:0] a, input logic [7:0] d, input string r);
    cyc(1, 0, 1, a, d, 0, 0, 0, 8'h00, 8'h00, plsb, r);
  endtask
  task automatic h_rd(input logic [1:0] a, input string r);
    cyc(1, 1, 0, a, 8'h00, 0, 0, 0, 8'h00, 8'h00, plsb, r);
  endtask
  task automatic c_wr(input logic [7:0] a, input logic [7:0] d, input logic pl, input string r);
    cyc(0, 0, 0, 2'd0, 8'h00, 1, 0, 1, a, d, pl, r);
  endtask
  task automatic c_rd(input logic [7:0] a, input logic pl, input string r);
    cyc(0, 0, 0, 2'd0, 8'h00, 1, 1, 0, a, 8'h00, pl, r);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    h_rd(2'd0, "R1 host status");
    c_rd(8'h01, 0, "R1 cmd byte");
    c_rd(8'h02, 0, "R1 inbound byte");
    h_rd(2'd1, "R1 outbound byte");
    // R3 command path, R2/R7 status layout
    h_wr(2'd0, 8'h5A, "R3 cmd write");
    h_rd(2'd0, "R2 status cflag");
    c_rd(8'h04, 0, "R7 cp status cflag");
    c_rd(8'h01, 0, "R3 cmd readback");
    // R4 clear via read and via write
    c_rd(8'h05, 0, "R4 clear read");
    c_rd(8'h04, 0, "R4 cflag cleared");
    h_wr(2'd0, 8'hC3, "R3 cmd write 2");
    c_wr(8'h05, 8'hFF, 0, "R4 clear write");
    h_rd(2'd0, "R4 cflag cleared by write");
    c_rd(8'h01, 0, "R3 cmd kept C3");
    // R5 inbound
    h_wr(2'd1, 8'hA7, "R5 host data write");
    h_rd(2'd0, "R5 dflag set");
    c_rd(8'h02, 0, "R5 inbound read");
    c_rd(8'h04, 0, "R5 dflag cleared");
    // R6 outbound
    c_wr(8'h03, 8'h3C, 0, "R6 cp data write");
    c_rd(8'h04, 0, "R6 dflag set");
    h_rd(2'd1, "R6 outbound read");
    h_rd(2'd0, "R6 dflag cleared");
    // R8 alias forcing, both polarities, read and write access
    c_rd(8'h0A, 0, "R8 alias read page0");
    h_rd(2'd0, "R8 dflag forced 1");
    c_wr(8'h0A, 8'h00, 1, "R8 alias write page1");
    h_rd(2'd0, "R8 dflag forced 0");
    // R9 same-cycle set and clear
    cyc(1, 0, 1, 2'd0, 8'h11, 1, 1, 0, 8'h05, 8'h00, 0, "R9 cflag set vs clear");
    c_rd(8'h04, 0, "R9 cflag set wins");
    cyc(1, 1, 0, 2'd1, 8'h00, 1, 0, 1, 8'h03, 8'h99, 0, "R9 dflag set vs clear");
    c_rd(8'h04, 0, "R9 dflag set wins");
    // R12 read same cycle as update returns old value
    cyc(1, 0, 1, 2'd1, 8'h42, 1, 1, 0, 8'h02, 8'h00, 0, "R12 old inbound");
    c_rd(8'h02, 0, "R12 new inbound");
    // R11 chip select low
    cyc(0, 0, 1, 2'd0, 8'hEE, 0, 0, 1, 8'h03, 8'h77, 0, "R11 no cs write");
    cyc(0, 0, 0, 2'd0, 8'h00, 0, 1, 1, 8'h05, 8'h00, 0, "R11 no cs clear");
    h_rd(2'd0, "R11 status unchanged");
    c_rd(8'h01, 0, "R11 cmd unchanged");
    h_rd(2'd1, "R11 outbound unchanged");
    // R10 control pulses
    h_wr(2'd2, 8'hA0, "R10 reset+led");
    h_wr(2'd2, 8'h40, "R10 nmi");
    h_wr(2'd2, 8'h1F, "R10 low bits ignored");
    h_rd(2'd2, "R2 undefined host read");
    c_rd(8'h07, 0, "R2 undefined cp read");
    repeat (2) @(negedge clk);
    chk({7'b0, o_rst | o_nmi | o_led}, 8'h00, "R10 pulses idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule